// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block is a register-mapped general-purpose I/O controller for up to 96 pins. Each function (direction, driven value, interrupt enable, interrupt polarity, interrupt type and interrupt status) has its own bank of 32-bit words. Each word covers 32 pins. Software reaches these words over a plain single-cycle register bus. The block drives the pin output values and their output enables. It samples the pin inputs through a synchroniser and turns qualified levels or edges into per-pin status bits. All pending status bits whose interrupt is enabled are OR-ed onto one interrupt line.

The number of implemented pins is a parameter. Register bits and status bits for pins at or beyond that count read as zero and never change. A rising-edge event on a pin and a software acknowledge of the same status bit may land in the same clock. The event then takes priority, so the event is not lost.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every register word reads 0, all pin_oe and pin_out bits are 0, and irq_out is 0.
- R2: Bank k starts at byte address k*16, in this order: 0 output enable, 1 drive, 2 interrupt enable, 3 polarity, 4 type, 5 status. The word holding pin n is at bank base + (n/32)*4, and pin n is bit n%32 of that word. A write to banks 0 to 4 is read back masked to the implemented pins.
- R3: pin_oe[n] equals bit n of the output-enable bank, where 1 means output. pin_out[n] equals bit n of the drive bank.
- R4: A read of the drive bank returns the pin inputs after two clock edges of synchronisation, not the stored drive value.
- R5: With type bit 1 and polarity bit 0, a 0-to-1 input change sets the status bit three edges after the input changes. The bit stays set until a write of 1 to it. Writing 0 to it has no effect.
- R6: With type bit 1 and polarity bit 1, only a 1-to-0 input change sets the status bit.
- R7: With type bit 0, the status bit follows the synchronised level: the high level when polarity is 0, the low level when polarity is 1. A write of 1 does not clear it while that level is active.
- R8: irq_out is 1 exactly when some status bit is 1 and its interrupt-enable bit is also 1. A status bit still latches while its pin's interrupt is disabled.
- R9: When an edge event and a write of 1 to the same status bit occur in the same cycle, the bit ends set.
- R10: Reads of unmapped addresses return 0, and writes to them change nothing. Unmapped addresses are bank index 6 or 7, a word index at or beyond the implemented word count, or address bits [1:0] not zero.
- R11: Bits for pins at or beyond NUM_PINS read 0 in every bank and never drive a pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the access |
| pin_in | input | NUM_PINS | Pin input levels |
| pin_out | output | NUM_PINS | Pin drive values |
| pin_oe | output | NUM_PINS | Pin output enables |
| irq_out | output | 1 | Combined interrupt |

## Verification
Two things can hit a status bit in the same clock: a newly detected edge that sets it, and a software write of 1 that clears it. The bench first leaves the bit set from an earlier edge. It then drops the pin and raises it again. The clearing write is timed to land on exactly the edge where the synchroniser reports the new rise. The bit must read back as 1 afterwards. A second clear one cycle later, with no event, must bring it to 0.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int unsigned WORD_W    = 32;
   localparam int unsigned MAX_PINS  = 96;
   localparam int unsigned ADDR_W    = 7;
   localparam int unsigned NUM_CFG   = 5;
   localparam int unsigned NUM_BANKS = 6;

   typedef enum logic [2:0] {
      BK_OE  = 3'd0,
      BK_DRV = 3'd1,
      BK_IEN = 3'd2,
      BK_POL = 3'd3,
      BK_TYP = 3'd4,
      BK_STA = 3'd5
   } bank_e;

   // bits of register word 'word' that correspond to implemented pins
   function automatic logic [WORD_W-1:0] impl_mask(input int unsigned pins,
                                                   input int unsigned word);
      logic [WORD_W-1:0] m;
      m = '0;
      for (int unsigned i = 0; i < WORD_W; i++)
         m[i] = ((word * WORD_W + i) < pins);
      return m;
   endfunction
endpackage

// File: rtl/gpio_reg_word.sv
module gpio_reg_word #(
   parameter int unsigned      WIDTH = 32,
   parameter logic [WIDTH-1:0] MASK  = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata & MASK;
   end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned WIDTH = 96
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw,
   output logic [WIDTH-1:0] cur,
   output logic [WIDTH-1:0] prev
);
   logic [WIDTH-1:0] meta_q, cur_q, prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         meta_q <= '0;
         cur_q  <= '0;
         prev_q <= '0;
      end else begin
         meta_q <= raw;
         cur_q  <= meta_q;
         prev_q <= cur_q;
      end
   end

   assign cur  = cur_q;
   assign prev = prev_q;
endmodule

// File: rtl/gpio_evt_word.sv
module gpio_evt_word #(
   parameter int unsigned      WIDTH = 32,
   parameter logic [WIDTH-1:0] MASK  = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] prev,
   input  logic [WIDTH-1:0] pol,
   input  logic [WIDTH-1:0] typ,
   input  logic [WIDTH-1:0] clr,
   output logic [WIDTH-1:0] sta
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (MASK[i]) begin : g_pin
         logic q_now, q_old, evt, sta_q;
         assign q_now = cur[i] ^ pol[i];
         assign q_old = prev[i] ^ pol[i];
         assign evt   = q_now & ~q_old;

         always_ff @(posedge clk) begin
            if (!rst_n)      sta_q <= 1'b0;
            else if (typ[i]) sta_q <= (sta_q & ~clr[i]) | evt;
            else             sta_q <= q_now;
         end
         assign sta[i] = sta_q;

         AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (typ[i] && sta_q && !clr[i]) |=> sta_q);                  // R5
         AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (typ[i] && evt) |=> sta_q);                               // R9
         AST_LEVEL_ON: assert property (@(posedge clk) disable iff (!rst_n)
            (!typ[i] && q_now) |=> sta_q);                            // R7
         AST_LEVEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            (!typ[i] && !q_now) |=> !sta_q);                          // R7
      end else begin : g_none
         logic unused_bits;
         assign unused_bits = ^{cur[i], prev[i], pol[i], typ[i], clr[i]};
         assign sta[i] = 1'b0;
      end
   end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NUM_PINS = 67
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [WORD_W-1:0]   bus_wdata,
   output logic [WORD_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic                irq_out
);
   localparam int unsigned NWORDS = (NUM_PINS + WORD_W - 1) / WORD_W;
   localparam int unsigned PW     = NWORDS * WORD_W;

   if (NUM_PINS < 1 || NUM_PINS > MAX_PINS) begin : g_bad_pins
      $error("gpio_bank_ctrl: NUM_PINS out of range");
   end

   logic [2:0] bank;
   logic [1:0] widx;
   logic       hit;
   assign bank = bus_addr[6:4];
   assign widx = bus_addr[3:2];
   assign hit  = (bus_addr[1:0] == 2'b00) && (bank <= BK_STA) &&
                 ({30'd0, widx} < NWORDS);

   logic [NUM_CFG-1:0][PW-1:0] cfg_q;
   logic [PW-1:0] pin_pad, sync_cur, sync_prev, sta_all;
   logic [WORD_W-1:0] rd_word [NUM_BANKS][NWORDS];

   assign pin_pad = PW'(pin_in);

   gpio_in_sync #(.WIDTH(PW)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw(pin_pad),
      .cur(sync_cur), .prev(sync_prev)
   );

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      localparam logic [WORD_W-1:0] WMASK = impl_mask(NUM_PINS, w);

      for (genvar b = 0; b < NUM_CFG; b++) begin : g_cfg
         logic we_b;
         assign we_b = bus_sel && bus_wr && hit &&
                       (bank == 3'(b)) && (widx == 2'(w));
         gpio_reg_word #(.WIDTH(WORD_W), .MASK(WMASK)) u_reg (
            .clk(clk), .rst_n(rst_n), .we(we_b), .wdata(bus_wdata),
            .q(cfg_q[b][w*WORD_W +: WORD_W])
         );
         if (b == int'(BK_DRV)) begin : g_pad_rd
            assign rd_word[b][w] = sync_cur[w*WORD_W +: WORD_W];
         end else begin : g_cfg_rd
            assign rd_word[b][w] = cfg_q[b][w*WORD_W +: WORD_W];
         end
      end

      logic              we_sta;
      logic [WORD_W-1:0] clr_w;
      assign we_sta = bus_sel && bus_wr && hit &&
                      (bank == BK_STA) && (widx == 2'(w));
      assign clr_w  = we_sta ? bus_wdata : '0;

      gpio_evt_word #(.WIDTH(WORD_W), .MASK(WMASK)) u_evt (
         .clk  (clk),
         .rst_n(rst_n),
         .cur  (sync_cur [w*WORD_W +: WORD_W]),
         .prev (sync_prev[w*WORD_W +: WORD_W]),
         .pol  (cfg_q[BK_POL][w*WORD_W +: WORD_W]),
         .typ  (cfg_q[BK_TYP][w*WORD_W +: WORD_W]),
         .clr  (clr_w),
         .sta  (sta_all[w*WORD_W +: WORD_W])
      );
      assign rd_word[BK_STA][w] = sta_all[w*WORD_W +: WORD_W] & WMASK;
   end

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < int'(NUM_BANKS); b++)
         for (int w = 0; w < int'(NWORDS); w++)
            if (hit && bank == 3'(b) && widx == 2'(w))
               bus_rdata = rd_word[b][w];
   end

   assign pin_oe  = cfg_q[BK_OE][NUM_PINS-1:0];
   assign pin_out = cfg_q[BK_DRV][NUM_PINS-1:0];
   assign irq_out = |(sta_all & cfg_q[BK_IEN]);

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_wr) |=> $stable(cfg_q));                       // R2
   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (|cfg_q[BK_IEN]));                                  // R8
endmodule

// File: tb/test_gpio_bank_ctrl.sv
module test_gpio_bank_ctrl;
   localparam int NP = 67;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n;
   logic          bus_sel, bus_wr;
   logic [6:0]    bus_addr;
   logic [31:0]   bus_wdata, bus_rdata;
   logic [NP-1:0] pins, pin_out, pin_oe;
   logic          irq_out;

   gpio_bank_ctrl #(.NUM_PINS(NP)) i_gpio_bank_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pins), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
   );

   int checks = 0;
   int errors = 0;
   logic [31:0] cfgm [5][3];
   logic [31:0] stam [3];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] msk(input int w);
      logic [31:0] m;
      for (int i = 0; i < 32; i++) m[i] = ((w * 32 + i) < NP);
      return m;
   endfunction

   function automatic logic [6:0] adr(input int b, input int w);
      return 7'(b * 16 + w * 4);
   endfunction

   task automatic bwr(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic brd(input logic [6:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; pins = '0; bus_sel = 1'b0; bus_wr = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      for (int b = 0; b < 5; b++) for (int w = 0; w < 3; w++) cfgm[b][w] = '0;
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v, d;
      logic [NP-1:0] old_p, nw;
      int b, w;
      void'($urandom(5417));
      bus_addr = '0; bus_wdata = '0;
      do_reset();

      // R1: reset state
      for (int bb = 0; bb < 6; bb++)
         for (int ww = 0; ww < 3; ww++) begin
            brd(adr(bb, ww), v);
            chk("R1 reg", v, 32'h0);
         end
      chk("R1 pin_oe", {29'd0, pin_oe[66:64]} | pin_oe[31:0] | pin_oe[63:32], 32'h0);
      chk("R1 pin_out", pin_out[31:0] | pin_out[63:32] | {29'd0, pin_out[66:64]}, 32'h0);
      chk("R1 irq", {31'd0, irq_out}, 32'h0);

      // R2: random readback of config banks
      for (int it = 0; it < 40; it++) begin
         b = int'($urandom % 5); w = int'($urandom % 3); d = $urandom;
         bwr(adr(b, w), d);
         cfgm[b][w] = d & msk(w);
         if (b != 1) begin
            brd(adr(b, w), v);
            chk("R2 readback", v, cfgm[b][w]);
         end
      end

      // R10: unmapped writes ignored, reads zero
      bwr(7'h60, 32'hFFFF_FFFF);
      bwr(7'h70, 32'hFFFF_FFFF);
      bwr(7'h0C, 32'hFFFF_FFFF);
      bwr(7'h31, 32'hFFFF_FFFF);
      brd(7'h60, v); chk("R10 bank6", v, 32'h0);
      brd(7'h0C, v); chk("R10 word3", v, 32'h0);
      brd(7'h31, v); chk("R10 misaligned", v, 32'h0);
      for (int bb = 0; bb < 5; bb++)
         if (bb != 1)
            for (int ww = 0; ww < 3; ww++) begin
               brd(adr(bb, ww), v);
               chk("R10 unchanged", v, cfgm[bb][ww]);
            end

      // R3 / R11: direction and drive
      do_reset();
      bwr(adr(0, 1), 32'hFFFF_FFFF);
      bwr(adr(1, 1), 32'hA5A5_5A5A);
      bwr(adr(0, 2), 32'hFFFF_FFFF);
      bwr(adr(1, 2), 32'hFFFF_FFFA);
      chk("R3 oe", pin_oe[63:32], 32'hFFFF_FFFF);
      chk("R3 out", pin_out[63:32], 32'hA5A5_5A5A);
      chk("R3 oe low word", pin_oe[31:0], 32'h0);
      chk("R11 out top", {29'd0, pin_out[66:64]}, 32'h2);
      brd(adr(0, 2), v); chk("R11 oe word2", v, 32'h7);

      // R4: pad read through two-edge synchroniser
      do_reset();
      pins = NP'({$urandom, $urandom, $urandom});
      repeat (3) @(posedge clk);
      old_p = pins;
      @(negedge clk) pins = ~old_p;
      brd(adr(1, 0), v); chk("R4 latency", v, old_p[31:0]);
      brd(adr(1, 0), v); chk("R4 pad w0", v, ~old_p[31:0]);
      brd(adr(1, 2), v); chk("R4 pad w2", v, {29'd0, ~old_p[66:64]});

      // R5: rising edge, sticky, write-0 ignored, write-1 clears
      do_reset();
      bwr(adr(4, 0), 32'h1);
      bwr(adr(2, 0), 32'h1);
      @(negedge clk) pins[0] = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk) chk("R5 not yet", {31'd0, irq_out}, 32'h0);
      @(posedge clk);
      @(negedge clk) chk("R5 irq", {31'd0, irq_out}, 32'h1);
      bwr(adr(5, 0), 32'h0);
      brd(adr(5, 0), v); chk("R5 write0", v, 32'h1);
      bwr(adr(5, 0), 32'h1);
      brd(adr(5, 0), v); chk("R5 clear", v, 32'h0);
      chk("R5 irq off", {31'd0, irq_out}, 32'h0);

      // R6: falling edge on pin 33
      do_reset();
      bwr(adr(4, 1), 32'h2);
      bwr(adr(3, 1), 32'h2);
      repeat (3) @(posedge clk);
      brd(adr(5, 1), v); chk("R6 idle", v, 32'h0);
      @(negedge clk) pins[33] = 1'b1;
      repeat (3) @(posedge clk);
      brd(adr(5, 1), v); chk("R6 rise ignored", v, 32'h0);
      @(negedge clk) pins[33] = 1'b0;
      repeat (3) @(posedge clk);
      brd(adr(5, 1), v); chk("R6 fall", v, 32'h2);

      // R7 / R8: level mode on pins 40 (high) and 41 (low)
      do_reset();
      bwr(adr(3, 1), 32'h200);
      repeat (3) @(posedge clk);
      brd(adr(5, 1), v); chk("R7 low active", v, 32'h200);
      chk("R8 disabled", {31'd0, irq_out}, 32'h0);
      bwr(adr(2, 1), 32'h200);
      chk("R8 enabled", {31'd0, irq_out}, 32'h1);
      @(negedge clk) pins[40] = 1'b1;
      repeat (3) @(posedge clk);
      brd(adr(5, 1), v); chk("R7 high active", v, 32'h300);
      bwr(adr(5, 1), 32'h300);
      brd(adr(5, 1), v); chk("R7 no clear", v, 32'h300);
      @(negedge clk) begin pins[40] = 1'b0; pins[41] = 1'b1; end
      repeat (3) @(posedge clk);
      brd(adr(5, 1), v); chk("R7 inactive", v, 32'h0);
      chk("R8 none pending", {31'd0, irq_out}, 32'h0);

      // R9: edge and clear in the same cycle
      do_reset();
      bwr(adr(4, 0), 32'h4);
      @(negedge clk) pins[2] = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk) pins[2] = 1'b0;
      repeat (3) @(posedge clk);
      brd(adr(5, 0), v); chk("R9 pre", v, 32'h4);
      @(negedge clk) pins[2] = 1'b1;
      @(posedge clk); @(posedge clk);
      bwr(adr(5, 0), 32'h4);
      brd(adr(5, 0), v); chk("R9 set wins", v, 32'h4);
      bwr(adr(5, 0), 32'h4);
      brd(adr(5, 0), v); chk("R9 later clear", v, 32'h0);

      // R5 / R11: random rising-edge traffic against a model
      do_reset();
      for (int ww = 0; ww < 3; ww++) begin
         bwr(adr(4, ww), 32'hFFFF_FFFF);
         stam[ww] = '0;
      end
      old_p = '0;
      for (int it = 0; it < 25; it++) begin
         nw = NP'({$urandom, $urandom, $urandom});
         @(negedge clk) pins = nw;
         repeat (4) @(posedge clk);
         stam[0] |= nw[31:0] & ~old_p[31:0];
         stam[1] |= nw[63:32] & ~old_p[63:32];
         stam[2] |= {29'd0, nw[66:64] & ~old_p[66:64]};
         old_p = nw;
         for (int ww = 0; ww < 3; ww++) begin
            brd(adr(5, ww), v);
            chk("R5 R11 random status", v, stam[ww]);
         end
         w = int'($urandom % 3); d = $urandom;
         bwr(adr(5, w), d);
         stam[w] &= ~d;
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule